// File: doc/BRIEF.md
# Wiper Position Counter with Bus-Clocked Stepping

This block keeps the volatile position of a 64-tap resistor ladder and turns it into a registered one-hot tap select for the analog switch array. A command slave upstream decodes the serial bus. It hands this block three things: one-cycle load strobes, a flag that stays high while stepping is armed, and already-synchronized copies of the serial clock and data lines.

The position can change in four ways. A direct write places a 6-bit value from the bus. A bank transfer copies one of the nonvolatile data registers, whose contents arrive as a flat bus. While stepping is armed, each rising edge of the serial clock moves the wiper one tap. The data line level at that edge picks the direction, and the wiper stops at either end instead of wrapping. In the first cycle after reset, the value of data register 0 is recalled. The tap select follows the position one clock later and always has exactly one bit set.

Top module: `wiper_ctr`

## Requirements
- R1: `tap_sel` has exactly one bit set in every cycle, including during reset.
- R2: Position 0 drives `tap_sel[0]` (the low-end terminal) and position 63 drives `tap_sel[63]` (the high-end terminal); in general bit N marks position N.
- R3: While `step_en` is high, a rising edge of `scl_s` with `sda_s` high raises `wiper_pos` by one in the clock after that edge is seen.
- R4: While `step_en` is high, a rising edge of `scl_s` with `sda_s` low lowers `wiper_pos` by one.
- R5: Stepping saturates: an up step at 63 leaves 63 and a down step at 0 leaves 0.
- R6: With `step_en` low, edges on `scl_s` leave `wiper_pos` unchanged.
- R7: One SCL high phase yields exactly one step, however many clocks it lasts; up and down steps may be mixed freely within one armed period.
- R8: While `rst` is high `wiper_pos` is 0; in the first clock after `rst` falls, `wiper_pos` takes data register 0 (`dreg_bus[5:0]`).
- R9: A cycle with `wr_en` high loads `wr_val` into `wiper_pos` on the next edge.
- R10: A cycle with `xfr_en` high loads data register `xfr_sel` (bits `6*xfr_sel+5 : 6*xfr_sel` of `dreg_bus`) into `wiper_pos`.
- R11: Priority when sources coincide: reset recall, then `wr_en`, then `xfr_en`, then a step.
- R12: `tap_sel` reflects the `wiper_pos` value of the previous clock; its reset value is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_s | input | 1 | Synchronized serial clock level |
| sda_s | input | 1 | Synchronized serial data level (step direction) |
| step_en | input | 1 | Stepping armed (instruction acknowledged until STOP) |
| wr_en | input | 1 | Direct load strobe |
| wr_val | input | 6 | Direct load value |
| xfr_en | input | 1 | Bank transfer strobe |
| xfr_sel | input | 2 | Data register index for transfer |
| dreg_bus | input | 24 | Four data registers, register k at bits 6k+5:6k |
| wiper_pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | Registered one-hot tap select |

## Verification
Some properties can be checked on every cycle, and the assertions do that. They check that the tap select stays one-hot and tracks the previous position. They check that the position moves by at most one tap when no load is pending, that it holds at either end for the matching direction, that it stays still when nothing is armed or strobed, and that direct loads land. Only the bench scenarios can show the rest. That covers the recall value after reset, the exact step count for long SCL high phases, and which data register a transfer picks. It also covers the priority order when a write, a transfer and an edge coincide, and the pattern of direction changes within one armed period.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_DIRECT = 3'd2,
    SRC_BANK   = 3'd3,
    SRC_STEP   = 3'd4
  } wc_src_e;
endpackage

// File: rtl/wc_scl_edge.sv
module wc_scl_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic rise,
  output logic dir_up
);
  logic scl_q;

  // Reset to high so an SCL already high at reset release is not taken as an edge.
  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b1;
    else     scl_q <= scl_s;
  end

  assign rise   = scl_s & ~scl_q;
  assign dir_up = sda_s;
endmodule

// File: rtl/wc_src_sel.sv
module wc_src_sel
  import wc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_en,
  input  logic    xfr_en,
  input  logic    step_en,
  input  logic    rise,
  output logic    recall_pend,
  output wc_src_e src
);
  always_ff @(posedge clk) begin
    if (rst) recall_pend <= 1'b1;
    else     recall_pend <= 1'b0;
  end

  always_comb begin
    if (recall_pend)          src = SRC_RECALL;
    else if (wr_en)           src = SRC_DIRECT;
    else if (xfr_en)          src = SRC_BANK;
    else if (step_en && rise) src = SRC_STEP;
    else                      src = SRC_HOLD;
  end
endmodule

// File: rtl/wc_pos_reg.sv
module wc_pos_reg
  import wc_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  wc_src_e          src,
  input  logic [POS_W-1:0] recall_val,
  input  logic [POS_W-1:0] wr_val,
  input  logic [POS_W-1:0] bank_val,
  input  logic             dir_up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  logic [POS_W-1:0] stepped;
  logic [POS_W-1:0] nxt;

  always_comb begin
    if (dir_up) stepped = (pos == TOP) ? pos : pos + ONE;
    else        stepped = (pos == '0)  ? pos : pos - ONE;
  end

  always_comb begin
    unique case (src)
      SRC_RECALL: nxt = recall_val;
      SRC_DIRECT: nxt = wr_val;
      SRC_BANK:   nxt = bank_val;
      SRC_STEP:   nxt = stepped;
      default:    nxt = pos;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= nxt;
  end
endmodule

// File: rtl/wc_tap_dec.sv
module wc_tap_dec #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap[i] <= (i == 0);
      else     tap[i] <= (pos == POS_W'(i));
    end
  end
endmodule

// File: rtl/wiper_ctr.sv
module wiper_ctr
  import wc_pkg::*;
#(
  parameter int POS_W    = 6,
  parameter int NUM_DREG = 4,
  localparam int TAPS    = 1 << POS_W,
  localparam int SEL_W   = (NUM_DREG > 1) ? $clog2(NUM_DREG) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_s,
  input  logic                      sda_s,
  input  logic                      step_en,
  input  logic                      wr_en,
  input  logic [POS_W-1:0]          wr_val,
  input  logic                      xfr_en,
  input  logic [SEL_W-1:0]          xfr_sel,
  input  logic [NUM_DREG*POS_W-1:0] dreg_bus,
  output logic [POS_W-1:0]          wiper_pos,
  output logic [TAPS-1:0]           tap_sel
);
  logic [POS_W-1:0] bank [NUM_DREG];
  logic [POS_W-1:0] bank_val;
  logic             rise;
  logic             dir_up;
  logic             recall_pend;
  wc_src_e          src;

  for (genvar k = 0; k < NUM_DREG; k++) begin : g_bank
    assign bank[k] = dreg_bus[k*POS_W +: POS_W];
  end

  always_comb begin
    bank_val = bank[0];
    for (int k = 0; k < NUM_DREG; k++)
      if (xfr_sel == SEL_W'(k)) bank_val = bank[k];
  end

  wc_scl_edge u_edge (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .rise(rise), .dir_up(dir_up)
  );

  wc_src_sel u_sel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .xfr_en(xfr_en),
    .step_en(step_en), .rise(rise), .recall_pend(recall_pend), .src(src)
  );

  wc_pos_reg #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .src(src), .recall_val(bank[0]),
    .wr_val(wr_val), .bank_val(bank_val), .dir_up(dir_up), .pos(wiper_pos)
  );

  wc_tap_dec #(.POS_W(POS_W)) u_dec (
    .clk(clk), .rst(rst), .pos(wiper_pos), .tap(tap_sel)
  );
endmodule

// File: rtl/wiper_ctr_chk.sv
module wiper_ctr_chk #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_s,
  input logic             step_en,
  input logic             wr_en,
  input logic [POS_W-1:0] wr_val,
  input logic             xfr_en,
  input logic             recall_pend,
  input logic [POS_W-1:0] wiper_pos,
  input logic [TAPS-1:0]  tap_sel
);
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

  logic quiet;
  assign quiet = !wr_en && !xfr_en && !recall_pend;

  // R1
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1);

  // R12: the select tracks the position of the cycle before
  p_tap_follow_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tap_sel[$past(wiper_pos)] == 1'b1);

  // R6: nothing armed or strobed, nothing moves
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (quiet && !step_en) |=> $stable(wiper_pos));

  // R7: without a load the position moves at most one tap
  p_unit_step_r7: assert property (@(posedge clk) disable iff (rst)
    quiet |=> ((wiper_pos == $past(wiper_pos)) ||
               ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)} + 1'b1) ||
               ({1'b0, $past(wiper_pos)} == {1'b0, wiper_pos} + 1'b1)));

  // R5: saturation at both ends
  p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
    (quiet && sda_s && wiper_pos == TOP) |=> wiper_pos == TOP);

  p_sat_bot_r5: assert property (@(posedge clk) disable iff (rst)
    (quiet && !sda_s && wiper_pos == '0) |=> wiper_pos == '0);

  // R9
  p_direct_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !recall_pend) |=> wiper_pos == $past(wr_val));
endmodule

bind wiper_ctr wiper_ctr_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .sda_s(sda_s), .step_en(step_en),
  .wr_en(wr_en), .wr_val(wr_val), .xfr_en(xfr_en),
  .recall_pend(recall_pend), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
);

// File: tb/tb_wiper_ctr.sv
module tb_wiper_ctr;
  localparam int W = 6;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl_s = 1'b0, sda_s = 1'b0, step_en = 1'b0;
  logic          wr_en = 1'b0, xfr_en = 1'b0;
  logic [W-1:0]  wr_val = '0;
  logic [1:0]    xfr_sel = '0;
  logic [N*W-1:0] dreg_bus;
  logic [W-1:0]  wiper_pos;
  logic [63:0]   tap_sel;

  int vecs = 0;
  int bad  = 0;

  int    exp_q[$];
  string tag_q[$];

  int m_pos;
  bit m_scl;
  bit m_recall;

  always #5 clk = ~clk;

  wiper_ctr dut (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .step_en(step_en),
    .wr_en(wr_en), .wr_val(wr_val), .xfr_en(xfr_en), .xfr_sel(xfr_sel),
    .dreg_bus(dreg_bus), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: drives one cycle of stimulus and pushes the position expected after the next edge.
  task automatic apply(input bit scl, input bit sda, input bit en,
                       input bit wr, input int wv, input bit xf, input int xs,
                       input string tag);
    bit rise;
    @(negedge clk);
    rst = 1'b0;
    scl_s = scl; sda_s = sda; step_en = en;
    wr_en = wr; wr_val = W'(wv); xfr_en = xf; xfr_sel = 2'(xs);
    rise = scl && !m_scl;
    m_scl = scl;
    if (m_recall) begin
      m_pos = int'(dreg_bus[W-1:0]);
      m_recall = 1'b0;
    end else if (wr)      m_pos = wv;
    else if (xf)          m_pos = int'(dreg_bus[xs*W +: W]);
    else if (en && rise) begin
      if (sda) m_pos = (m_pos == 63) ? 63 : m_pos + 1;
      else     m_pos = (m_pos == 0)  ? 0  : m_pos - 1;
    end
    exp_q.push_back(m_pos);
    tag_q.push_back(tag);
  endtask

  task automatic pulse(input bit sda, input bit en, input string tag);
    apply(1'b1, sda, en, 1'b0, 0, 1'b0, 0, tag);
    apply(1'b0, sda, en, 1'b0, 0, 1'b0, 0, tag);
  endtask

  task automatic idle(input string tag);
    apply(m_scl, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, tag);
  endtask

  task automatic chk_tap(input int idx, input string tag);
    @(posedge clk); #3;
    check(tap_sel == (64'd1 << idx), tag, tap_sel, 64'd1 << idx);
  endtask

  // Monitor: pops expectations after each edge and compares position and select.
  initial begin
    int prev;
    prev = 0;
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(wiper_pos) == e, t, wiper_pos, e);
        check(tap_sel == (64'd1 << prev), {t, " R12 select lag"}, tap_sel, 64'd1 << prev);
        prev = e;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    dreg_bus = {6'h2A, 6'h07, 6'h33, 6'h15};
    m_scl = 1'b1; m_recall = 1'b1; m_pos = 0;
    repeat (3) @(posedge clk);
    #3;
    check(wiper_pos == 0, "R8 reset position", wiper_pos, 0);
    check(tap_sel == 64'd1, "R12 reset select R1", tap_sel, 1);

    idle("R8 recall reg0");
    idle("R8 hold after recall");

    pulse(1'b1, 1'b1, "R3 up");
    pulse(1'b1, 1'b1, "R3 up");
    apply(1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b0, 0, "R7 long high");
    apply(1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b0, 0, "R7 long high");
    apply(1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0, "R7 long high");
    apply(1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0, "R7 low");
    pulse(1'b0, 1'b1, "R4 down");
    pulse(1'b1, 1'b1, "R7 mixed up");
    pulse(1'b0, 1'b1, "R4 mixed down");
    pulse(1'b0, 1'b1, "R4 down");

    pulse(1'b1, 1'b0, "R6 disarmed");
    pulse(1'b0, 1'b0, "R6 disarmed");

    apply(1'b0, 1'b0, 1'b0, 1'b1, 62, 1'b0, 0, "R9 direct 62");
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1, "R5 top sat");
    idle("R5 hold");
    chk_tap(63, "R2 high end");
    apply(1'b0, 1'b0, 1'b0, 1'b1, 1, 1'b0, 0, "R9 direct 1");
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, "R5 bottom sat");
    idle("R5 hold");
    chk_tap(0, "R2 low end");

    apply(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 2, "R10 bank 2");
    apply(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 3, "R10 bank 3");
    apply(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1, "R10 bank 1");
    apply(1'b0, 1'b0, 1'b0, 1'b1, 9, 1'b1, 3, "R11 direct beats bank");
    apply(1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b1, 0, "R11 bank beats step");
    apply(1'b0, 1'b1, 1'b1, 1'b1, 40, 1'b0, 0, "R11 direct");
    apply(1'b1, 1'b1, 1'b1, 1'b1, 20, 1'b0, 0, "R11 direct beats step");
    idle("R1 settle");
    idle("R1 settle");

    wait (exp_q.size() == 0);
    @(posedge clk); #3;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule